// File: doc/BRIEF.md
# Bridge System Error Event Reporter

This block gathers error events from the posted-write and delayed-transaction engines of a bus bridge. It converts each enabled event into a one-clock active-low pulse on the primary-bus system-error line. A sticky cause register records every event that occurs, even when the event is masked and does not produce a pulse. Software reads this register to find out why the line was driven, and clears bits by writing ones to them.

Three of the events do not come from an engine directly. Retry counters produce them: one for posted-write delivery, one for delayed-write delivery and one for delayed-read fetches. Each counter counts target retries for the transaction in flight. It raises an exhaustion event when the count reaches a programmable limit, which defaults to 2^24. A counter restarts when its transaction completes or is aborted.

Six events each have their own mask bit in a disable register. Master timeout on a delayed transaction has no mask bit of its own. A separate bridge-control enable input gates it instead. Every pulse also needs the global system-error enable.

Top module: `serr_event_reporter`

## Requirements
- R1: After reset the cause register reads 0, the disable register reads 0, the retry limit reads 2^24 (0x1000000), and `serr_n_o` is high.
- R2: The cause register (address 0) uses this bit layout: bit0 posted-write target abort, bit1 posted-write master abort, bit2 posted-write parity error reported, bit3 posted-write retry exhaustion, bit4 delayed-write retry exhaustion, bit5 delayed-read retry exhaustion, bit6 delayed master timeout. An event sets its bit at the clock edge that samples the event, and the bit stays set.
- R3: An enabled event sampled at an edge drives `serr_n_o` low for exactly the following clock cycle. Several events in the same cycle give a single one-cycle pulse.
- R4: A 1 in bit n (n = 0..5) of the disable register (address 1) stops event n from driving `serr_n_o`. The event still sets its cause bit, and the other events are not affected.
- R5: Disable bit 6 does not exist: it reads 0 and writing it has no effect. Master timeout pulses `serr_n_o` only when `mto_serr_en_i` is 1.
- R6: When `serr_en_i` is 0, no event drives `serr_n_o` low. Cause bits are still set.
- R7: Writing address 0 clears each cause bit written with a 1 and leaves the other bits alone. An event arriving in the same cycle as the clearing write wins, so its bit stays set.
- R8: The retry limit is held at address 2. On each counter, the retry that brings the count to the limit raises that counter's exhaustion event, and the counter then restarts from zero. The three counters are independent of each other.
- R9: A done pulse clears its counter. A done pulse and a retry in the same cycle clear the counter and do not count the retry.
- R10: With a limit of 0 or 1, every retry raises an exhaustion event. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| serr_en_i | input | 1 | Global system-error enable |
| mto_serr_en_i | input | 1 | Bridge-control enable for the master-timeout event |
| pw_tabort_i | input | 1 | Posted write ended in target abort |
| pw_mabort_i | input | 1 | Posted write ended in master abort |
| pw_parity_i | input | 1 | Parity error reported on the target bus during a posted write |
| dly_mto_i | input | 1 | Master timeout on a delayed transaction |
| pw_retry_i | input | 1 | Target retry seen on posted-write delivery |
| pw_done_i | input | 1 | Posted-write transaction completed or aborted |
| dw_retry_i | input | 1 | Target retry seen on delayed-write delivery |
| dw_done_i | input | 1 | Delayed-write transaction completed or aborted |
| dr_retry_i | input | 1 | Target retry seen on delayed-read fetch |
| dr_done_i | input | 1 | Delayed-read transaction completed or aborted |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 cause, 1 disable, 2 limit, 3 reserved |
| reg_wdata_i | input | 25 | Register write data |
| reg_rdata_o | output | 25 | Register read data for the address on reg_addr_i (combinational) |
| serr_n_o | output | 1 | Active-low system-error pulse |

## Verification
Each posted-write event is first fired alone, then two events together, to separate a per-source pulse from a merged single pulse and to confirm that the cause bits land at the right positions. Masked, globally disabled and bridge-control-gated cases show that status recording and pulse generation are separate: status changes while the line stays high. The retry counters are driven with a small programmed limit through several sequences: an exact count to the limit, a count that restarts after exhaustion, a done pulse in mid-count, and a done pulse coinciding with a retry. Together these tell an off-by-one threshold apart from a missing clear. Limits of 0 and 1 cover the degenerate threshold.

// File: rtl/serr_pkg.sv
package serr_pkg;

    localparam int NUM_EV   = 7;
    localparam int NUM_MASK = 6;
    localparam int NUM_CTR  = 3;

    // event bit positions in the cause register
    localparam int EV_PW_TABORT = 0;
    localparam int EV_PW_MABORT = 1;
    localparam int EV_PW_PARITY = 2;
    localparam int EV_PW_RETRY  = 3;
    localparam int EV_DW_RETRY  = 4;
    localparam int EV_DR_RETRY  = 5;
    localparam int EV_DLY_MTO   = 6;

    typedef logic [NUM_EV-1:0]   ev_vec_t;
    typedef logic [NUM_MASK-1:0] mask_vec_t;

    typedef enum logic [1:0] {
        RA_CAUSE = 2'd0,
        RA_MASK  = 2'd1,
        RA_LIMIT = 2'd2,
        RA_RSVD  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic retry;
        logic done;
    } ctr_in_t;

    // sticky update: new events win over a write-one-to-clear
    function automatic ev_vec_t sticky_next(ev_vec_t cur, ev_vec_t set, ev_vec_t clr);
        return (cur & ~clr) | set;
    endfunction

endpackage

// File: rtl/serr_retry_ctr.sv
module serr_retry_ctr
    import serr_pkg::*;
#(
    parameter int LIM_W = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  ctr_in_t          ctl_i,
    input  logic [LIM_W-1:0] limit_i,
    output logic             exhaust_o
);

    logic [LIM_W-1:0] cnt_q;
    logic [LIM_W:0]   cnt_inc;
    logic             hit;

    always_comb begin
        cnt_inc   = {1'b0, cnt_q} + {{LIM_W{1'b0}}, 1'b1};
        hit       = cnt_inc >= {1'b0, limit_i};
        exhaust_o = ctl_i.retry && !ctl_i.done && hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ctl_i.done) begin
            cnt_q <= '0;
        end else if (ctl_i.retry) begin
            if (hit) cnt_q <= '0;
            else     cnt_q <= cnt_inc[LIM_W-1:0];
        end
    end

    // R8: counter restarts after exhaustion
    a_r8_restart_after_exhaust: assert property (@(posedge clk) disable iff (rst)
        exhaust_o |=> (cnt_q == '0));

    // R9: done always clears the count
    a_r9_done_clears: assert property (@(posedge clk) disable iff (rst)
        ctl_i.done |=> (cnt_q == '0));

    // R9: done with retry never raises an exhaustion
    a_r9_done_blocks_exhaust: assert property (@(posedge clk) disable iff (rst)
        ctl_i.done |-> !exhaust_o);

endmodule

// File: rtl/serr_regs.sv
module serr_regs
    import serr_pkg::*;
#(
    parameter int               LIM_W     = 25,
    parameter logic [LIM_W-1:0] DEF_LIMIT = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic [1:0]       addr_i,
    input  logic [LIM_W-1:0] wdata_i,
    output logic [LIM_W-1:0] rdata_o,
    input  ev_vec_t          ev_set_i,
    output ev_vec_t          cause_o,
    output mask_vec_t        mask_o,
    output logic [LIM_W-1:0] limit_o
);

    ev_vec_t          cause_q;
    mask_vec_t        mask_q;
    logic [LIM_W-1:0] limit_q;
    ev_vec_t          clr_vec;
    reg_addr_e        ra;

    always_comb begin
        ra      = reg_addr_e'(addr_i);
        clr_vec = (wr_i && ra == RA_CAUSE) ? wdata_i[NUM_EV-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
            mask_q  <= '0;
            limit_q <= DEF_LIMIT;
        end else begin
            cause_q <= sticky_next(cause_q, ev_set_i, clr_vec);
            if (wr_i && ra == RA_MASK)  mask_q  <= wdata_i[NUM_MASK-1:0];
            if (wr_i && ra == RA_LIMIT) limit_q <= wdata_i;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (ra)
            RA_CAUSE: rdata_o[NUM_EV-1:0]   = cause_q;
            RA_MASK:  rdata_o[NUM_MASK-1:0] = mask_q;
            RA_LIMIT: rdata_o               = limit_q;
            default:  rdata_o               = '0;
        endcase
    end

    assign cause_o = cause_q;
    assign mask_o  = mask_q;
    assign limit_o = limit_q;

    // R2: without a clearing write no cause bit drops
    a_r2_cause_sticky: assert property (@(posedge clk) disable iff (rst)
        !(wr_i && ra == RA_CAUSE) |=> (($past(cause_q) & ~cause_q) == '0));

    // R7: an event always leaves its bit set, even against a clear
    a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (ev_set_i != '0) |=> ((cause_q & $past(ev_set_i)) == $past(ev_set_i)));

endmodule

// File: rtl/serr_flag_gen.sv
module serr_flag_gen
    import serr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ev_vec_t   ev_i,
    input  mask_vec_t mask_i,
    input  logic      serr_en_i,
    input  logic      mto_en_i,
    output logic      serr_n_o
);

    ev_vec_t allow;
    logic    fire;

    always_comb begin
        allow                       = '0;
        allow[NUM_MASK-1:0]         = ~mask_i;
        allow[EV_DLY_MTO]           = mto_en_i;
        fire                        = serr_en_i && ((ev_i & allow) != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) serr_n_o <= 1'b1;
        else     serr_n_o <= !fire;
    end

    // R6: global enable off means the line stays high next cycle
    a_r6_global_gate: assert property (@(posedge clk) disable iff (rst)
        !serr_en_i |=> serr_n_o);

    // R3: no pulse without an event in the previous cycle
    a_r3_pulse_needs_event: assert property (@(posedge clk) disable iff (rst)
        (ev_i == '0) |=> serr_n_o);

    // R5: master timeout alone without its enable gives no pulse
    a_r5_mto_gated: assert property (@(posedge clk) disable iff (rst)
        (ev_i == ev_vec_t'(1 << EV_DLY_MTO) && !mto_en_i) |=> serr_n_o);

endmodule

// File: rtl/serr_event_reporter.sv
module serr_event_reporter
    import serr_pkg::*;
#(
    parameter int LIMIT_LOG2 = 24,
    localparam int LIM_W     = LIMIT_LOG2 + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             serr_en_i,
    input  logic             mto_serr_en_i,
    input  logic             pw_tabort_i,
    input  logic             pw_mabort_i,
    input  logic             pw_parity_i,
    input  logic             dly_mto_i,
    input  logic             pw_retry_i,
    input  logic             pw_done_i,
    input  logic             dw_retry_i,
    input  logic             dw_done_i,
    input  logic             dr_retry_i,
    input  logic             dr_done_i,
    input  logic             reg_wr_i,
    input  logic [1:0]       reg_addr_i,
    input  logic [LIM_W-1:0] reg_wdata_i,
    output logic [LIM_W-1:0] reg_rdata_o,
    output logic             serr_n_o
);

    localparam logic [LIM_W-1:0] DEF_LIMIT = LIM_W'(1) << LIMIT_LOG2;
    localparam int               CTR_BASE  = EV_PW_RETRY;

    ctr_in_t          ctr_in [NUM_CTR];
    logic [NUM_CTR-1:0] exhaust;
    logic [LIM_W-1:0] limit;
    mask_vec_t        mask;
    ev_vec_t          cause;
    ev_vec_t          ev_all;

    always_comb begin
        ctr_in[0] = '{retry: pw_retry_i, done: pw_done_i};
        ctr_in[1] = '{retry: dw_retry_i, done: dw_done_i};
        ctr_in[2] = '{retry: dr_retry_i, done: dr_done_i};
    end

    for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
        serr_retry_ctr #(.LIM_W(LIM_W)) u_ctr (
            .clk       (clk),
            .rst       (rst),
            .ctl_i     (ctr_in[k]),
            .limit_i   (limit),
            .exhaust_o (exhaust[k])
        );
    end

    always_comb begin
        ev_all                                  = '0;
        ev_all[EV_PW_TABORT]                    = pw_tabort_i;
        ev_all[EV_PW_MABORT]                    = pw_mabort_i;
        ev_all[EV_PW_PARITY]                    = pw_parity_i;
        ev_all[CTR_BASE +: NUM_CTR]             = exhaust;
        ev_all[EV_DLY_MTO]                      = dly_mto_i;
    end

    serr_regs #(.LIM_W(LIM_W), .DEF_LIMIT(DEF_LIMIT)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (reg_wr_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .rdata_o  (reg_rdata_o),
        .ev_set_i (ev_all),
        .cause_o  (cause),
        .mask_o   (mask),
        .limit_o  (limit)
    );

    serr_flag_gen u_flag (
        .clk       (clk),
        .rst       (rst),
        .ev_i      (ev_all),
        .mask_i    (mask),
        .serr_en_i (serr_en_i),
        .mto_en_i  (mto_serr_en_i),
        .serr_n_o  (serr_n_o)
    );

    // R3/R2: every pulse is backed by a recorded cause
    a_r3_pulse_has_cause: assert property (@(posedge clk) disable iff (rst)
        !serr_n_o |-> (cause != '0));

    // R4: a masked posted-write abort alone gives no pulse
    a_r4_mask_blocks: assert property (@(posedge clk) disable iff (rst)
        (mask[EV_PW_MABORT] && pw_mabort_i && !pw_tabort_i && !pw_parity_i
         && exhaust == '0 && !dly_mto_i) |=> serr_n_o);

endmodule

// File: tb/tb_serr_event_reporter.sv
`timescale 1ns/1ps
module tb_serr_event_reporter;

    localparam int LIM_W = 25;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic serr_en = 1'b1, mto_en = 1'b1;
    logic pw_tabort = 0, pw_mabort = 0, pw_parity = 0, mto = 0;
    logic [2:0] retry = '0, done = '0;
    logic reg_wr = 0;
    logic [1:0] reg_addr = '0;
    logic [LIM_W-1:0] reg_wdata = '0;
    logic [LIM_W-1:0] rdata;
    logic serr_n;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    serr_event_reporter dut (
        .clk(clk), .rst(rst), .serr_en_i(serr_en), .mto_serr_en_i(mto_en),
        .pw_tabort_i(pw_tabort), .pw_mabort_i(pw_mabort), .pw_parity_i(pw_parity),
        .dly_mto_i(mto),
        .pw_retry_i(retry[0]), .pw_done_i(done[0]),
        .dw_retry_i(retry[1]), .dw_done_i(done[1]),
        .dr_retry_i(retry[2]), .dr_done_i(done[2]),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(rdata), .serr_n_o(serr_n)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(logic [1:0] a, logic [LIM_W-1:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0; reg_addr = 0; reg_wdata = '0;
    endtask

    task automatic rd_reg(logic [1:0] a, output logic [LIM_W-1:0] d);
        @(negedge clk); reg_addr = a;
        #1 d = rdata;
        reg_addr = 0;
    endtask

    task automatic fire(logic [2:0] pw, logic m, output bit lo1, output bit lo2);
        @(negedge clk); {pw_parity, pw_mabort, pw_tabort} = pw; mto = m;
        @(posedge clk); #1 lo1 = !serr_n;
        @(negedge clk); {pw_parity, pw_mabort, pw_tabort} = '0; mto = 0;
        @(posedge clk); #1 lo2 = !serr_n;
    endtask

    task automatic rtry(logic [2:0] r, logic [2:0] d, output bit lo1);
        @(negedge clk); retry = r; done = d;
        @(posedge clk); #1 lo1 = !serr_n;
        @(negedge clk); retry = '0; done = '0;
    endtask

    task automatic clear_cause();
        wr_reg(2'd0, 25'h7F);
    endtask

    task automatic t_reset();
        logic [LIM_W-1:0] d;
        chk("R1 serr_n after reset", serr_n, 1);
        rd_reg(0, d); chk("R1 cause reset", d, 0);
        rd_reg(1, d); chk("R1 disable reset", d, 0);
        rd_reg(2, d); chk("R1 limit reset", d, 32'h100_0000);
        rd_reg(3, d); chk("R10 reserved reads 0", d, 0);
    endtask

    task automatic t_direct();
        bit l1, l2;
        logic [LIM_W-1:0] d;
        for (int i = 0; i < 3; i++) begin
            fire(3'(1 << i), 0, l1, l2);
            chk("R3 pulse low", l1, 1);
            chk("R3 pulse one cycle", l2, 0);
            rd_reg(0, d); chk("R2 cause bit", d, 32'(1 << i));
            clear_cause();
        end
    endtask

    task automatic t_simul();
        bit l1, l2;
        logic [LIM_W-1:0] d;
        fire(3'b101, 0, l1, l2);
        chk("R3 merged low", l1, 1);
        chk("R3 merged single", l2, 0);
        rd_reg(0, d); chk("R2 two causes", d, 32'h05);
        wr_reg(0, 25'h01);
        rd_reg(0, d); chk("R7 partial clear", d, 32'h04);
        clear_cause();
        rd_reg(0, d); chk("R7 full clear", d, 0);
        @(negedge clk); reg_wr = 1; reg_addr = 0; reg_wdata = 25'h01; pw_tabort = 1;
        @(negedge clk); reg_wr = 0; reg_wdata = '0; pw_tabort = 0;
        rd_reg(0, d); chk("R7 set beats clear", d, 32'h01);
        clear_cause();
    endtask

    task automatic t_mask();
        bit l1, l2;
        logic [LIM_W-1:0] d;
        wr_reg(1, 25'h02);
        fire(3'b010, 0, l1, l2);
        chk("R4 masked no pulse", l1, 0);
        rd_reg(0, d); chk("R4 masked still sets cause", d, 32'h02);
        fire(3'b001, 0, l1, l2);
        chk("R4 unmasked still pulses", l1, 1);
        wr_reg(1, 25'h00);
        clear_cause();
    endtask

    task automatic t_mto();
        bit l1, l2;
        logic [LIM_W-1:0] d;
        mto_en = 0;
        fire(0, 1, l1, l2);
        chk("R5 mto gated off", l1, 0);
        rd_reg(0, d); chk("R5 mto sets cause", d, 32'h40);
        clear_cause();
        mto_en = 1;
        fire(0, 1, l1, l2);
        chk("R5 mto enabled pulses", l1, 1);
        wr_reg(1, 25'h7F);
        rd_reg(1, d); chk("R5 no disable bit 6", d, 32'h3F);
        fire(0, 1, l1, l2);
        chk("R5 mto ignores disable reg", l1, 1);
        wr_reg(1, 25'h00);
        clear_cause();
    endtask

    task automatic t_global();
        bit l1, l2;
        logic [LIM_W-1:0] d;
        serr_en = 0;
        fire(3'b001, 0, l1, l2);
        chk("R6 no pulse when global off", l1, 0);
        fire(0, 1, l1, l2);
        chk("R6 mto no pulse when global off", l1, 0);
        rd_reg(0, d); chk("R6 causes still set", d, 32'h41);
        serr_en = 1;
        clear_cause();
    endtask

    task automatic t_retry();
        bit l;
        logic [LIM_W-1:0] d;
        wr_reg(2, 25'd3);
        rd_reg(2, d); chk("R8 limit readback", d, 3);
        rtry(3'b001, 0, l); chk("R8 retry 1 quiet", l, 0);
        rtry(3'b001, 0, l); chk("R8 retry 2 quiet", l, 0);
        rd_reg(0, d); chk("R8 no cause before limit", d, 0);
        rtry(3'b001, 0, l); chk("R8 retry 3 exhausts", l, 1);
        rd_reg(0, d); chk("R8 pw exhaust cause", d, 32'h08);
        clear_cause();
        rtry(3'b001, 0, l); chk("R8 restart 1", l, 0);
        rtry(3'b001, 0, l); chk("R8 restart 2", l, 0);
        rtry(3'b000, 3'b001, l);
        rtry(3'b001, 0, l); chk("R9 after done 1", l, 0);
        rtry(3'b001, 0, l); chk("R9 after done 2", l, 0);
        rtry(3'b001, 3'b001, l); chk("R9 done with retry quiet", l, 0);
        rtry(3'b001, 0, l); chk("R9 cleared count 1", l, 0);
        rtry(3'b001, 0, l); chk("R9 cleared count 2", l, 0);
        rtry(3'b010, 0, l); chk("R8 dw counter independent", l, 0);
        rtry(3'b001, 0, l); chk("R9 cleared count 3", l, 1);
        rd_reg(0, d); chk("R8 only pw cause", d, 32'h08);
        clear_cause();
    endtask

    task automatic t_small_limit();
        bit l;
        logic [LIM_W-1:0] d;
        rtry(3'b000, 3'b111, l);
        wr_reg(2, 25'd1);
        rtry(3'b010, 0, l); chk("R10 limit 1 exhausts", l, 1);
        rtry(3'b010, 0, l); chk("R10 limit 1 again", l, 1);
        rd_reg(0, d); chk("R10 dw cause", d, 32'h10);
        clear_cause();
        wr_reg(2, 25'd0);
        rtry(3'b100, 0, l); chk("R10 limit 0 exhausts", l, 1);
        rd_reg(0, d); chk("R10 dr cause", d, 32'h20);
        clear_cause();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        t_reset();
        t_direct();
        t_simul();
        t_mask();
        t_mto();
        t_global();
        t_retry();
        t_small_limit();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule